// File: doc/BRIEF.md
# Block Address Translation Matcher

This unit translates an effective address into a physical page address using two small arrays of block descriptors: one for instruction fetches and one for data accesses. Each descriptor is a pair of 32-bit words. The upper word holds a block base, a block-length field and two privilege-valid bits. The lower word holds the physical block base. A lookup is purely combinational over the stored descriptors. It returns a hit flag, the index of the winning entry and the 4 KB-aligned physical address.

Software reaches the descriptors through a special-register port. The port decodes a 10-bit register number into one word of one entry. Accepted numbers can be read back combinationally and written on the clock edge. Every accepted write raises a one-cycle `inval_o` pulse so that downstream translation caches can drop stale results.

Top module: `bat_match`

## Requirements
- R1: After reset every word of every descriptor reads as zero, no lookup hits, and `inval_o` is low.
- R2: An entry takes part in a lookup only if its selected valid bit is set. With `pr_i`=0 (supervisor) the selected bit is bit 1 of the upper word. With `pr_i`=1 (user) it is bit 0.
- R3: The block-length field sits in upper-word bits [12:2]. Address bits [27:17] are compared only where that field holds a zero, address bits [31:28] are always compared, and bits below 17 are never compared. The stored base is upper-word bits [31:17].
- R4: On a hit, `pa_o` equals the lower word with bits [16:0] cleared, plus the effective address with bits [11:0] cleared, minus the stored base (modulo 2^32). As a result, `pa_o[11:0]` is zero.
- R5: When several entries match, the lowest index wins and is reported on `idx_o`.
- R6: `side_i`=0 looks up the instruction array and `side_i`=1 looks up the data array. Entries of the other array have no effect on the result.
- R7: A register number is accepted only when its bits [9:5] are 5'h10 or 5'h11. For any other number a read returns zero, and a write changes no descriptor and gives no `inval_o` pulse.
- R8: For an accepted number, bit 3 selects the array (0 instruction, 1 data). The entry index is {bit 5, bits [2:1]}. Bit 0 selects the word (0 upper, 1 lower). Bit 4 is ignored.
- R9: An accepted write sets `inval_o` high for exactly the cycle after the write edge. Without a further accepted write, `inval_o` then returns low.
- R10: On a miss, `hit_o`, `idx_o` and `pa_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| side_i | input | 1 | Array select: 0 instruction, 1 data |
| pr_i | input | 1 | Problem state: 0 supervisor, 1 user |
| ea_i | input | 32 | Effective address to translate |
| hit_o | output | 1 | A valid entry matched |
| idx_o | output | 3 | Index of the matching entry |
| pa_o | output | 32 | Physical page address |
| spr_num_i | input | 10 | Special-register number |
| spr_we_i | input | 1 | Write strobe |
| spr_wdata_i | input | 32 | Write data |
| spr_rdata_o | output | 32 | Read data for `spr_num_i` |
| inval_o | output | 1 | One-cycle translation-cache flush pulse |

## Verification
The bench builds the unit with its default parameters: a 32-bit address, a 17-bit block boundary and an 11-bit length field. With these values a single descriptor set reaches both the smallest 128 KB block (length field zero) and the largest 256 MB block (all ones), as well as a 2 MB and a 256 KB block in between. Descriptors are placed at indices 5 and 7, which can only be reached through register-number bit 5, and they overlap so that index priority decides the result. A second pass repeats the overlapping lookup after the winning entry has been disabled.

// File: rtl/bat_match.sv
`timescale 1ns/1ps
module bat_match #(
  parameter int AW        = 32,
  parameter int BLK_SHIFT = 17,
  parameter int BL_W      = 11,
  parameter int PG_SHIFT  = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          side_i,
  input  logic          pr_i,
  input  logic [AW-1:0] ea_i,
  output logic          hit_o,
  output logic [2:0]    idx_o,
  output logic [AW-1:0] pa_o,
  input  logic [9:0]    spr_num_i,
  input  logic          spr_we_i,
  input  logic [AW-1:0] spr_wdata_i,
  output logic [AW-1:0] spr_rdata_o,
  output logic          inval_o
);
  localparam int NENT   = 8;
  localparam int BL_LSB = 2;
  localparam logic [AW-1:0] BLK_MASK = {AW{1'b1}} << BLK_SHIFT;
  localparam logic [AW-1:0] PG_MASK  = {AW{1'b1}} << PG_SHIFT;

  logic [AW-1:0] up_r [2][NENT];
  logic [AW-1:0] lo_r [2][NENT];

  wire       acc     = (spr_num_i[9:6] == 4'b1000);
  wire       w_side  = spr_num_i[3];
  wire [2:0] w_idx   = {spr_num_i[5], spr_num_i[2:1]};
  wire       w_lower = spr_num_i[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < 2; s++)
        for (int e = 0; e < NENT; e++) begin
          up_r[s][e] <= '0;
          lo_r[s][e] <= '0;
        end
      inval_o <= 1'b0;
    end else begin
      inval_o <= spr_we_i && acc;
      if (spr_we_i && acc) begin
        if (w_lower) lo_r[w_side][w_idx] <= spr_wdata_i;
        else         up_r[w_side][w_idx] <= spr_wdata_i;
      end
    end
  end

  assign spr_rdata_o = !acc    ? '0 :
                       w_lower ? lo_r[w_side][w_idx] : up_r[w_side][w_idx];

  logic [NENT-1:0] match;
  logic [AW-1:0]   pa_e [NENT];

  for (genvar e = 0; e < NENT; e++) begin : g_ent
    wire [AW-1:0]   u    = up_r[side_i][e];
    wire [BL_W-1:0] bl   = u[BL_LSB +: BL_W];
    wire [AW-1:0]   blx  = AW'(bl);
    wire [AW-1:0]   msk  = (~blx) << BLK_SHIFT;
    wire [AW-1:0]   base = u & BLK_MASK;
    wire            ok   = pr_i ? u[0] : u[1];
    assign match[e] = ok && ((ea_i & msk) == base);
    assign pa_e[e]  = (lo_r[side_i][e] & BLK_MASK) + ((ea_i & PG_MASK) - base);
  end

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    pa_o  = '0;
    for (int e = NENT - 1; e >= 0; e--) begin
      if (match[e]) begin
        hit_o = 1'b1;
        idx_o = 3'(e);
        pa_o  = pa_e[e];
      end
    end
  end
endmodule

module bat_match_chk #(
  parameter int AW       = 32,
  parameter int PG_SHIFT = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hit_o,
  input logic [2:0]    idx_o,
  input logic [AW-1:0] pa_o,
  input logic [9:0]    spr_num_i,
  input logic          spr_we_i,
  input logic [AW-1:0] spr_rdata_o,
  input logic          inval_o
);
  a_r9_inval_set: assert property (@(posedge clk) disable iff (!rst_n)
    (spr_we_i && spr_num_i[9:6] == 4'b1000) |=> inval_o);

  a_r9_inval_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(spr_we_i && spr_num_i[9:6] == 4'b1000) |=> !inval_o);

  a_r10_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |-> (pa_o == '0 && idx_o == 3'd0));

  a_r4_page_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (pa_o[PG_SHIFT-1:0] == '0));

  a_r7_reject_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (spr_num_i[9:6] != 4'b1000) |-> (spr_rdata_o == '0));
endmodule

bind bat_match bat_match_chk #(.AW(AW), .PG_SHIFT(PG_SHIFT)) u_chk (
  .clk(clk), .rst_n(rst_n), .hit_o(hit_o), .idx_o(idx_o), .pa_o(pa_o),
  .spr_num_i(spr_num_i), .spr_we_i(spr_we_i), .spr_rdata_o(spr_rdata_o),
  .inval_o(inval_o)
);

// File: tb/tb_bat_match.sv
`timescale 1ns/1ps
module tb_bat_match;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        side_i = 1'b0, pr_i = 1'b0;
  logic [31:0] ea_i = '0;
  logic        hit_o;
  logic [2:0]  idx_o;
  logic [31:0] pa_o;
  logic [9:0]  spr_num_i = '0;
  logic        spr_we_i = 1'b0;
  logic [31:0] spr_wdata_i = '0;
  logic [31:0] spr_rdata_o;
  logic        inval_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bat_match dut (
    .clk(clk), .rst_n(rst_n), .side_i(side_i), .pr_i(pr_i), .ea_i(ea_i),
    .hit_o(hit_o), .idx_o(idx_o), .pa_o(pa_o), .spr_num_i(spr_num_i),
    .spr_we_i(spr_we_i), .spr_wdata_i(spr_wdata_i), .spr_rdata_o(spr_rdata_o),
    .inval_o(inval_o)
  );

  // {side, pr, ea, hit, idx, pa}
  localparam int NV = 11;
  localparam logic [69:0] VEC [NV] = '{
    {1'b0, 1'b0, 32'h0001_2345, 1'b1, 3'd0, 32'h0101_2000},
    {1'b0, 1'b1, 32'h0001_2345, 1'b1, 3'd1, 32'h2001_2000},
    {1'b0, 1'b0, 32'h0234_5678, 1'b1, 3'd1, 32'h2234_5000},
    {1'b0, 1'b0, 32'h1000_0000, 1'b0, 3'd0, 32'h0000_0000},
    {1'b1, 1'b0, 32'h8000_1000, 1'b1, 3'd5, 32'h0040_1000},
    {1'b1, 1'b0, 32'h801F_FFFF, 1'b1, 3'd5, 32'h005F_F000},
    {1'b1, 1'b0, 32'h8020_0000, 1'b0, 3'd0, 32'h0000_0000},
    {1'b1, 1'b1, 32'hC003_0ABC, 1'b1, 3'd2, 32'h0503_0000},
    {1'b1, 1'b0, 32'hC003_0ABC, 1'b0, 3'd0, 32'h0000_0000},
    {1'b1, 1'b1, 32'hC004_0000, 1'b0, 3'd0, 32'h0000_0000},
    {1'b0, 1'b0, 32'h8000_1000, 1'b0, 3'd0, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] n, input logic [31:0] d, input bit accepted);
    @(negedge clk);
    spr_we_i = 1'b1; spr_num_i = n; spr_wdata_i = d;
    @(negedge clk);
    spr_we_i = 1'b0;
    chk(accepted ? "R9 pulse" : "R7 no pulse", {31'b0, inval_o}, {31'b0, accepted});
    @(negedge clk);
    chk("R9 single cycle", {31'b0, inval_o}, 32'd0);
  endtask

  task automatic rd(input string req, input logic [9:0] n, input logic [31:0] exp);
    spr_num_i = n;
    #1;
    chk(req, spr_rdata_o, exp);
  endtask

  task automatic look(input string req, input logic s, input logic p, input logic [31:0] a,
                      input logic h, input logic [2:0] i, input logic [31:0] pa);
    side_i = s; pr_i = p; ea_i = a;
    #1;
    chk({req, " hit"}, {31'b0, hit_o}, {31'b0, h});
    chk({req, " idx"}, {29'b0, idx_o}, {29'b0, i});
    chk({req, " pa"}, pa_o, pa);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    look("R1", 1'b0, 1'b0, 32'h0000_0000, 1'b0, 3'd0, 32'h0);
    look("R1", 1'b1, 1'b1, 32'h8000_1000, 1'b0, 3'd0, 32'h0);
    rd("R1 readback", 10'h200, 32'h0);
    rd("R1 readback", 10'h22F, 32'h0);
    chk("R1 inval", {31'b0, inval_o}, 32'd0);

    // R8: program descriptors through decoded numbers
    wr(10'h200, 32'h0000_0002, 1'b1);  // I0 upper: 128KB, supervisor only
    wr(10'h201, 32'h0100_0000, 1'b1);
    wr(10'h202, 32'h0000_1FFF, 1'b1);  // I1 upper: 256MB, both
    wr(10'h203, 32'h2000_0000, 1'b1);
    wr(10'h20C, 32'hC000_0005, 1'b1);  // D2 upper: 256KB, user only
    wr(10'h20D, 32'h0500_0000, 1'b1);
    wr(10'h22A, 32'h8000_003F, 1'b1);  // D5 upper: 2MB, both
    wr(10'h22B, 32'h0040_0000, 1'b1);
    wr(10'h22E, 32'h8000_0003, 1'b1);  // D7 upper: 128KB, both
    wr(10'h22F, 32'h0300_0000, 1'b1);

    // R2 R3 R4 R5 R6 R10: vector table
    for (int v = 0; v < NV; v++) begin
      look($sformatf("R2/R3/R4/R5/R6/R10 vec%0d", v),
           VEC[v][69], VEC[v][68], VEC[v][67:36], VEC[v][35], VEC[v][34:32], VEC[v][31:0]);
    end

    // R8: readback through decode, bit 4 alias
    rd("R8 readback D5 lower", 10'h22B, 32'h0040_0000);
    rd("R8 readback D7 upper", 10'h22E, 32'h8000_0003);
    rd("R8 bit4 ignored", 10'h210, 32'h0000_0002);

    // R7: rejected numbers
    wr(10'h1F0, 32'hFFFF_FFFF, 1'b0);
    rd("R7 I0 upper kept", 10'h200, 32'h0000_0002);
    rd("R7 reject read", 10'h1F0, 32'h0);
    wr(10'h240, 32'hFFFF_FFFF, 1'b0);
    rd("R7 reject read", 10'h240, 32'h0);
    look("R7 lookup kept", 1'b0, 1'b0, 32'h0001_2345, 1'b1, 3'd0, 32'h0101_2000);

    // R5: disable D5, overlapping D7 now wins
    wr(10'h22A, 32'h0000_0000, 1'b1);
    look("R5 fallback", 1'b1, 1'b0, 32'h8001_F000, 1'b1, 3'd7, 32'h0301_F000);
    look("R3 128KB edge", 1'b1, 1'b1, 32'h8002_0000, 1'b0, 3'd0, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule